// File: doc/BRIEF.md
# Infrared Receive Byte Buffer with Event Status

This block sits between an infrared pulse encoder and the processor. The encoder hands it one run-length byte at a time, and may also signal that a burst has ended. The block keeps the bytes in a byte-wide first-in first-out buffer. Software reads them through a small 32-bit register window, where each read of the data offset removes one byte.

Three event flags collect what happened: overflow, end of burst, and buffer filled beyond a programmable trigger level. The flags stay set until software writes ones to clear them. Each flag has its own enable, and the enabled flags are ORed onto a single interrupt line. The window also holds the encoder's configuration, which the block drives straight out to the encoder:
- global enable
- receive enable
- mode
- input polarity inversion
- noise threshold
- idle threshold

The bus is a plain single-cycle port. Read data is combinational from the offset, and writes and pops take effect at the rising clock edge. Buffer depth is a parameter with a default of 64. It must be a power of two.

Top module: `ir_rx_fifo_regs`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero, all configuration outputs are zero, the buffer is empty and `irq` is low.
- R2: Offset 0x00 holds global enable (bit 0), receive enable (bit 1) and mode (bits 5:4). Offset 0x10 holds polarity invert (bit 2). Offset 0x34 holds noise threshold (bits 7:2) and idle threshold (bits 15:8). Each field reads back, drives its output, and all other bits read zero.
- R3: A read of offset 0x20 returns the oldest buffered byte in bits 7:0, with the other bits zero, and removes it at that edge, so bytes leave in arrival order.
- R4: The status word at offset 0x30 carries the live fill count starting at bit 8, in a field of clog2(DEPTH+1) bits (bits 14:8 at depth 64). The field reflects each push and pop from the clock edge that performs it.
- R5: A byte pushed while the buffer holds DEPTH bytes, with no pop in the same cycle, is discarded and sets status bit 0 (overflow). Buffer contents and count are unchanged.
- R6: Reading offset 0x20 while the buffer is empty returns zero and leaves the count at zero.
- R7: An end-of-burst pulse from the encoder sets status bit 1.
- R8: Status bit 4 (data available) sets on the edge after the fill count is strictly greater than the trigger level held at offset 0x2C from bit 8.
- R9: Writing offset 0x30 clears each of bits 0, 1 and 4 written as one, and leaves the others. 0xFF clears all three. A flag whose set condition holds in the same cycle stays set.
- R10: `irq` is high exactly when some status flag is set while its enable, at the same bit position (0, 1 or 4) of offset 0x2C, is one.
- R11: Offsets other than the six listed read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; a read of 0x20 pops |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the offset |
| sym_valid | input | 1 | Encoder byte valid |
| sym_data | input | 8 | Encoder run-length byte |
| sym_frame_end | input | 1 | Encoder end-of-burst pulse |
| cfg_global_en | output | 1 | Global enable |
| cfg_rx_en | output | 1 | Receive enable |
| cfg_mode | output | 2 | Mode select |
| cfg_invert | output | 1 | Input polarity invert |
| cfg_noise_thr | output | 6 | Noise threshold in samples |
| cfg_idle_thr | output | 8 | Idle threshold in samples |
| irq | output | 1 | Interrupt |

## Verification
The results fall due at different times:
- Register writes, pushes, pops, overflow and end-of-burst show at the ports one edge after the stimulus.
- Data available needs a second edge, because it is set from the registered count.
- Read data and `irq` are combinational from state.

The bench drives on falling edges and samples on the next falling edge. For data available, it inserts one idle cycle before reading status. It sweeps every fill level from empty through overflow and every trigger level on a small depth, and computes each expected value from the count it has pushed.

// File: rtl/ir_rx_pkg.sv
// Shared offsets, bit positions and types for the infrared receive buffer.
// Assumes byte offsets on an 8-bit address and a 32-bit data word.
package ir_rx_pkg;
    localparam logic [7:0] OFS_CTRL   = 8'h00;
    localparam logic [7:0] OFS_RXCTRL = 8'h10;
    localparam logic [7:0] OFS_DATA   = 8'h20;
    localparam logic [7:0] OFS_IEN    = 8'h2C;
    localparam logic [7:0] OFS_STAT   = 8'h30;
    localparam logic [7:0] OFS_SAMP   = 8'h34;

    localparam int BIT_OVF   = 0;
    localparam int BIT_PKT   = 1;
    localparam int BIT_AVAIL = 4;
    localparam int CNT_LSB   = 8;

    typedef struct packed {
        logic avail;
        logic pkt;
        logic ovf;
    } ev_flags_t;
endpackage

// File: rtl/ir_rx_byte_fifo.sv
// Byte first-in first-out buffer with fill counter.
// Assumes DEPTH is a power of two. A push when full is dropped unless a pop
// frees a slot in the same cycle; a pop when empty does nothing.
module ir_rx_byte_fifo #(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [7:0]    push_data,
    input  logic          pop,
    output logic [7:0]    head,
    output logic [CW-1:0] count,
    output logic          dropped
);
    localparam logic [CW-1:0] FULL_C = CW'(DEPTH);

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          take, put;

    // Decide which requests are honoured this cycle.
    always_comb begin
        take    = pop && (count != '0);
        put     = push && ((count != FULL_C) || take);
        dropped = push && !put;
        head    = (count == '0) ? 8'h00 : mem[rd_ptr];
    end

    // Store an accepted byte.
    always_ff @(posedge clk) begin
        if (put) mem[wr_ptr] <= push_data;
    end

    // Advance pointers and fill count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (put)  wr_ptr <= wr_ptr + 1'b1;
            if (take) rd_ptr <= rd_ptr + 1'b1;
            if (put && !take)      count <= count + 1'b1;
            else if (take && !put) count <= count - 1'b1;
        end
    end

    a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_C);
    a_r5_full_drop_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
        (push && count == FULL_C && !pop) |=> count == FULL_C);
    a_r6_empty_pop_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && count == '0 && !push) |=> count == '0);
endmodule

// File: rtl/ir_rx_status.sv
// Sticky event flags with write-one-to-clear and interrupt combining.
// Assumes set conditions win over a clear in the same cycle.
module ir_rx_status #(
    parameter int CW = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 drop,
    input  logic                 frame_end,
    input  logic [CW-1:0]        count,
    input  logic [CW-1:0]        level,
    input  ir_rx_pkg::ev_flags_t clr,
    input  ir_rx_pkg::ev_flags_t ien,
    output ir_rx_pkg::ev_flags_t flags,
    output logic                 irq
);
    import ir_rx_pkg::*;

    ev_flags_t set_ev;

    // Collect this cycle's set conditions.
    always_comb begin
        set_ev.ovf   = drop;
        set_ev.pkt   = frame_end;
        set_ev.avail = (count > level);
    end

    // Update sticky flags: clear requested bits, then apply sets.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~clr) | set_ev;
    end

    // Combine enabled flags into one interrupt.
    always_comb irq = |(flags & ien);

    a_r5_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> flags.ovf);
    a_r7_pkt_set: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> flags.pkt);
    a_r8_avail_set: assert property (@(posedge clk) disable iff (!rst_n)
        (count > level) |=> flags.avail);
endmodule

// File: rtl/ir_rx_fifo_regs.sv
// Register window for the infrared receive buffer: configuration registers,
// data pop, interrupt enables with trigger level, and status.
// Assumes a single-cycle bus: read data is combinational, writes and pops
// take effect at the rising edge.
module ir_rx_fifo_regs #(
    parameter int DEPTH = 64,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        sym_valid,
    input  logic [7:0]  sym_data,
    input  logic        sym_frame_end,
    output logic        cfg_global_en,
    output logic        cfg_rx_en,
    output logic [1:0]  cfg_mode,
    output logic        cfg_invert,
    output logic [5:0]  cfg_noise_thr,
    output logic [7:0]  cfg_idle_thr,
    output logic        irq
);
    import ir_rx_pkg::*;

    logic          gen_q, rxen_q, inv_q;
    logic [1:0]    mode_q;
    logic [5:0]    noise_q;
    logic [7:0]    idle_q;
    ev_flags_t     ien_q, clr, flags;
    logic [CW-1:0] lvl_q, count;
    logic [7:0]    head;
    logic          pop, dropped;

    // Decode pop and status clear strobes.
    always_comb begin
        pop       = bus_rd && (bus_addr == OFS_DATA);
        clr       = '0;
        if (bus_wr && bus_addr == OFS_STAT) begin
            clr.ovf   = bus_wdata[BIT_OVF];
            clr.pkt   = bus_wdata[BIT_PKT];
            clr.avail = bus_wdata[BIT_AVAIL];
        end
    end

    // Configuration and enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gen_q   <= 1'b0;
            rxen_q  <= 1'b0;
            mode_q  <= '0;
            inv_q   <= 1'b0;
            noise_q <= '0;
            idle_q  <= '0;
            ien_q   <= '0;
            lvl_q   <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                OFS_CTRL: begin
                    gen_q  <= bus_wdata[0];
                    rxen_q <= bus_wdata[1];
                    mode_q <= bus_wdata[5:4];
                end
                OFS_RXCTRL: inv_q <= bus_wdata[2];
                OFS_SAMP: begin
                    noise_q <= bus_wdata[7:2];
                    idle_q  <= bus_wdata[15:8];
                end
                OFS_IEN: begin
                    ien_q.ovf   <= bus_wdata[BIT_OVF];
                    ien_q.pkt   <= bus_wdata[BIT_PKT];
                    ien_q.avail <= bus_wdata[BIT_AVAIL];
                    lvl_q       <= bus_wdata[CNT_LSB +: CW];
                end
                default: ;
            endcase
        end
    end

    // Read data multiplexer.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_CTRL: begin
                bus_rdata[0]   = gen_q;
                bus_rdata[1]   = rxen_q;
                bus_rdata[5:4] = mode_q;
            end
            OFS_RXCTRL: bus_rdata[2] = inv_q;
            OFS_DATA:   bus_rdata[7:0] = head;
            OFS_IEN: begin
                bus_rdata[BIT_OVF]       = ien_q.ovf;
                bus_rdata[BIT_PKT]       = ien_q.pkt;
                bus_rdata[BIT_AVAIL]     = ien_q.avail;
                bus_rdata[CNT_LSB +: CW] = lvl_q;
            end
            OFS_STAT: begin
                bus_rdata[BIT_OVF]       = flags.ovf;
                bus_rdata[BIT_PKT]       = flags.pkt;
                bus_rdata[BIT_AVAIL]     = flags.avail;
                bus_rdata[CNT_LSB +: CW] = count;
            end
            OFS_SAMP: begin
                bus_rdata[7:2]  = noise_q;
                bus_rdata[15:8] = idle_q;
            end
            default: ;
        endcase
    end

    // Drive configuration outputs.
    always_comb begin
        cfg_global_en = gen_q;
        cfg_rx_en     = rxen_q;
        cfg_mode      = mode_q;
        cfg_invert    = inv_q;
        cfg_noise_thr = noise_q;
        cfg_idle_thr  = idle_q;
    end

    ir_rx_byte_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (sym_valid),
        .push_data (sym_data),
        .pop       (pop),
        .head      (head),
        .count     (count),
        .dropped   (dropped)
    );

    ir_rx_status #(.CW(CW)) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .drop      (dropped),
        .frame_end (sym_frame_end),
        .count     (count),
        .level     (lvl_q),
        .clr       (clr),
        .ien       (ien_q),
        .flags     (flags),
        .irq       (irq)
    );

    a_r6_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && count == '0) |-> bus_rdata == 32'h0);
    a_r2_ctrl_stable_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(cfg_mode) && $stable(cfg_idle_thr));
endmodule

// File: tb/tb_ir_rx_fifo_regs.sv
module tb_ir_rx_fifo_regs;
    localparam int D  = 8;
    localparam int CW = $clog2(D + 1);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sym_valid = 1'b0, sym_frame_end = 1'b0;
    logic [7:0]  sym_data = '0;
    logic        cfg_global_en, cfg_rx_en, cfg_invert, irq;
    logic [1:0]  cfg_mode;
    logic [5:0]  cfg_noise_thr;
    logic [7:0]  cfg_idle_thr;

    int n_run = 0, n_fail = 0;
    logic [31:0] rv;

    always #10 clk = ~clk;

    ir_rx_fifo_regs #(.DEPTH(D)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sym_valid(sym_valid), .sym_data(sym_data), .sym_frame_end(sym_frame_end),
        .cfg_global_en(cfg_global_en), .cfg_rx_en(cfg_rx_en), .cfg_mode(cfg_mode),
        .cfg_invert(cfg_invert), .cfg_noise_thr(cfg_noise_thr),
        .cfg_idle_thr(cfg_idle_thr), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic push(input logic [7:0] b);
        sym_valid = 1'b1; sym_data = b;
        @(posedge clk); @(negedge clk);
        sym_valid = 1'b0;
    endtask

    task automatic idle();
        @(posedge clk); @(negedge clk);
    endtask

    function automatic logic [31:0] cnt_of(input logic [31:0] s);
        return 32'((s >> 8) & ((1 << CW) - 1));
    endfunction

    task automatic drain();
        logic [31:0] t;
        for (int i = 0; i < D; i++) rd(8'h20, t);
    endtask

    initial begin
        #(200000 * 20);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(8'h30, rv); chk("R1 status", rv, 0);
        rd(8'h00, rv); chk("R1 ctrl", rv, 0);
        rd(8'h2C, rv); chk("R1 ien", rv, 0);
        chk("R1 outputs", {cfg_global_en, cfg_rx_en, cfg_mode, cfg_invert, cfg_noise_thr, cfg_idle_thr, irq}, 0);

        // R2 configuration fields
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, rv); chk("R2 ctrl all-ones", rv, 32'h33);
        chk("R2 ctrl outs", {cfg_global_en, cfg_rx_en, cfg_mode}, 4'b1111);
        wr(8'h00, 32'h21);
        rd(8'h00, rv); chk("R2 ctrl 0x21", rv, 32'h21);
        chk("R2 mode", cfg_mode, 2);
        wr(8'h10, 32'hFFFF);
        rd(8'h10, rv); chk("R2 rxctrl", rv, 32'h4);
        chk("R2 invert", cfg_invert, 1);
        wr(8'h34, 32'hFFFF_FFFF);
        rd(8'h34, rv); chk("R2 samp all-ones", rv, 32'hFFFC);
        wr(8'h34, (5 << 2) | (20 << 8));
        chk("R2 noise", cfg_noise_thr, 5);
        chk("R2 idle", cfg_idle_thr, 20);

        // R11 unmapped offsets
        wr(8'h04, 32'hFFFF_FFFF);
        rd(8'h04, rv); chk("R11 read 0x04", rv, 0);
        rd(8'h3C, rv); chk("R11 read 0x3C", rv, 0);
        rd(8'h00, rv); chk("R11 ctrl untouched", rv, 32'h21);

        // R6 empty read
        rd(8'h20, rv); chk("R6 empty data", rv, 0);
        rd(8'h30, rv); chk("R6 count stays", cnt_of(rv), 0);

        // R4 and R5 fill sweep through overflow
        for (int k = 1; k <= D; k++) begin
            push(8'h30 + 8'(k));
            rd(8'h30, rv); chk("R4 count after push", cnt_of(rv), k);
            chk("R5 no overflow yet", rv[0], 0);
        end
        push(8'hEE);
        rd(8'h30, rv);
        chk("R5 overflow flag", rv[0], 1);
        chk("R5 count held", cnt_of(rv), D);

        // R3 order, R4 count on pop
        for (int k = 1; k <= D; k++) begin
            rd(8'h20, rv); chk("R3 byte order", rv, 32'h30 + k);
            rd(8'h30, rv); chk("R4 count after pop", cnt_of(rv), D - k);
        end
        rd(8'h20, rv); chk("R6 empty after drain", rv, 0);

        // R9 write-one-to-clear
        wr(8'h30, 32'h01);
        rd(8'h30, rv); chk("R9 clear ovf only", rv[4:0], 5'b10000);
        wr(8'h30, 32'hFF);
        rd(8'h30, rv); chk("R9 clear all", rv, 0);
        // R7 end of burst
        sym_frame_end = 1'b1; idle(); sym_frame_end = 1'b0;
        rd(8'h30, rv); chk("R7 pkt flag", rv, 32'h2);
        wr(8'h30, 32'h02);
        rd(8'h30, rv); chk("R9 clear pkt", rv, 0);
        sym_frame_end = 1'b1;
        wr(8'h30, 32'h02);
        sym_frame_end = 1'b0;
        rd(8'h30, rv); chk("R9 set wins", rv, 32'h2);
        wr(8'h30, 32'hFF);

        // R8 trigger level sweep
        for (int lvl = 0; lvl < D - 1; lvl++) begin
            drain();
            wr(8'h2C, 32'(lvl) << 8);
            rd(8'h2C, rv); chk("R8 level readback", rv, 32'(lvl) << 8);
            wr(8'h30, 32'hFF);
            for (int k = 1; k <= D; k++) begin
                push(8'(k));
                idle();
                rd(8'h30, rv);
                chk("R8 avail vs level", rv[4], (k > lvl) ? 1 : 0);
            end
        end
        drain();
        wr(8'h30, 32'hFF);

        // R10 interrupt combining
        wr(8'h2C, 32'h0);
        sym_frame_end = 1'b1; idle(); sym_frame_end = 1'b0;
        chk("R10 pkt masked", irq, 0);
        wr(8'h2C, 32'h02);
        chk("R10 pkt enabled", irq, 1);
        wr(8'h2C, 32'h10);
        chk("R10 avail enable only", irq, 0);
        wr(8'h30, 32'hFF);
        wr(8'h2C, 32'h01);
        for (int k = 0; k < D; k++) push(8'(k));
        chk("R10 no overflow yet", irq, 0);
        push(8'hAA);
        chk("R10 overflow enabled", irq, 1);
        wr(8'h30, 32'h01);
        chk("R10 cleared", irq, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule